// File: doc/BRIEF.md
# Multiprocessor 8/9-bit UART

A full-duplex asynchronous serial port with two frame formats. The short format carries a start bit, eight data bits sent least significant bit first, and a stop bit. The long format inserts a programmable ninth bit before the stop bit. The long format runs at a fixed fraction of the core clock. The short format runs from an externally supplied oversampling tick, so the baud generator lives outside this block.

A strobe that writes the transmit buffer starts a transmission. A transmit flag rises as the stop bit goes onto the line. The receiver oversamples the line, votes on three samples at the middle of each bit, and decides at the final bit whether to keep the frame. That decision uses the frame format, a filter-enable bit, the received ninth or stop bit, and an overrun guard. With these, a node on an address-based multi-drop bus can ignore data frames until it sees an address frame. The same rule lets the receiver reject frames whose stop bit is missing. Both flags stay set until software clears them with a strobe.

Top module: `mp_uart`

## Requirements
- R1: Format select {sm0_i,sm1_i}: 2'b01 is the short format and 2'b10 is the long format. With 2'b00 or 2'b11 the port is off: buffer writes are ignored, txd_o stays 1, TI is not set and no frame is received.
- R2: In the short format the transmitted frame is: start bit 0, data bits 0 to 7 in that order, then stop bit 1. Each bit lasts 16 periods of baud_tick_i. txd_o idles at 1.
- R3: In the long format the frame is: start 0, data bits 0 to 7, a ninth bit equal to tb8_i as sampled at the buffer write, then stop 1. Each bit lasts 64 core clocks, or 32 core clocks when smod_i=1.
- R4: ti_o is set in the cycle the stop bit is driven onto txd_o and holds until ti_clr_i. A buffer write while a frame is in progress is ignored.
- R5: Reception starts on a 1-to-0 change of rxd_i seen on the oversampling grid. Each bit value is the majority of samples 7, 8 and 9 of 16. If the start bit votes 1, the receiver returns to idle and raises no RI.
- R6: With ovr_en_i=0, a frame that completes while ri_o=1 is dropped, and rbuf_o and rb8_o keep their values. With ovr_en_i=1 the frame overwrites them.
- R7: In the short format an accepted frame loads rbuf_o with the data, loads rb8_o with the received stop bit and sets ri_o. With sm2_i=1, a frame whose stop bit is 0 is dropped. With sm2_i=0 it is accepted with rb8_o=0.
- R8: In the long format rb8_o receives the ninth bit and the stop bit is ignored. With sm2_i=1 a frame with ninth bit 0 is dropped and a frame with ninth bit 1 is accepted. With sm2_i=0 every frame is accepted.
- R9: While ren_i=0 no frame is received and ri_o does not rise.
- R10: ri_o holds until ri_clr_i clears it. A flag set and its clear strobe in the same cycle leave the flag set.
- R11: Transmit and receive run concurrently: a frame sent on txd_o and looped back into rxd_i is received while the transmission is still in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | core clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| baud_tick_i | input | 1 | 16x oversampling tick for the short format |
| sm0_i | input | 1 | format select, upper bit |
| sm1_i | input | 1 | format select, lower bit |
| sm2_i | input | 1 | receive filter enable |
| smod_i | input | 1 | doubles the long-format rate |
| ren_i | input | 1 | receiver enable |
| ovr_en_i | input | 1 | allow an unread buffer to be overwritten |
| tb8_i | input | 1 | ninth bit to transmit, sampled at the write |
| buf_wr_i | input | 1 | transmit buffer write strobe |
| buf_wdata_i | input | 8 | byte to transmit |
| ti_clr_i | input | 1 | clears ti_o |
| ri_clr_i | input | 1 | clears ri_o |
| rxd_i | input | 1 | serial input |
| txd_o | output | 1 | serial output |
| ti_o | output | 1 | transmit done flag |
| ri_o | output | 1 | receive done flag |
| rb8_o | output | 1 | received ninth or stop bit |
| rbuf_o | output | 8 | received byte |

## Verification
The bench builds the block with its defaults: 16x oversampling, long-format divisors of 64 and 32, and 8 data bits. It pulses baud_tick_i every third clock, so a short-format bit lasts 48 clocks and a long-format bit lasts 64 or 32 clocks. With bits that short, every accept and drop rule, the start-glitch abort, the off formats and a looped-back duplex transfer all fit in a run of a few tens of thousands of cycles. The sampling margin of a few clocks per bit also tests the majority vote at its designed point rather than at a comfortable edge.

// File: rtl/mp_uart_pkg.sv
package mp_uart_pkg;
  typedef enum logic [1:0] {
    FMT_OFF = 2'd0,
    FMT_10  = 2'd1,
    FMT_11  = 2'd2
  } fmt_e;

  function automatic fmt_e decode_fmt(input logic sm0, input logic sm1);
    case ({sm0, sm1})
      2'b01:   return FMT_10;
      2'b10:   return FMT_11;
      default: return FMT_OFF;
    endcase
  endfunction
endpackage

// File: rtl/mp_uart_rate.sv
module mp_uart_rate
  import mp_uart_pkg::*;
#(
  parameter int OVS      = 16,
  parameter int SLOW_DIV = 64,
  parameter int FAST_DIV = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  fmt_e fmt_i,
  input  logic smod_i,
  input  logic baud_tick_i,
  output logic tick_o
);
  localparam int SLOW_STEP = SLOW_DIV / OVS;
  localparam int FAST_STEP = FAST_DIV / OVS;
  localparam int CW = (SLOW_STEP > 1) ? $clog2(SLOW_STEP) : 1;
  localparam logic [CW-1:0] SLOW_LAST = CW'(SLOW_STEP - 1);
  localparam logic [CW-1:0] FAST_LAST = CW'(FAST_STEP - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;
  logic          fix_tick;

  assign lim      = smod_i ? FAST_LAST : SLOW_LAST;
  assign fix_tick = (fmt_i == FMT_11) && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (fmt_i != FMT_11)  cnt_q <= '0;
    else if (cnt_q >= lim)     cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    unique case (fmt_i)
      FMT_10:  tick_o = baud_tick_i;
      FMT_11:  tick_o = fix_tick;
      default: tick_o = 1'b0;
    endcase
  end

  AST_NO_TICK_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_i == FMT_OFF) |-> !tick_o); // R1
endmodule

// File: rtl/mp_uart_tx.sv
module mp_uart_tx
  import mp_uart_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  fmt_e          fmt_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          tb8_i,
  input  logic          ti_clr_i,
  output logic          txd_o,
  output logic          ti_o
);
  localparam int FW = DW + 3;
  localparam int IW = $clog2(FW);
  localparam int OW = $clog2(OVS);
  localparam logic [OW-1:0] OCNT_LAST = OW'(OVS - 1);
  localparam logic [IW-1:0] LAST_10   = IW'(DW + 1);
  localparam logic [IW-1:0] LAST_11   = IW'(DW + 2);

  logic [FW-1:0] frame_q;
  logic [IW-1:0] idx_q, last_q;
  logic [OW-1:0] ocnt_q;
  logic          busy_q, txd_q, ti_q;
  logic          bit_end, ti_set;

  assign bit_end = busy_q && tick_i && (ocnt_q == OCNT_LAST);
  assign ti_set  = bit_end && (idx_q != last_q) && ((idx_q + 1'b1) == last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '1;
      idx_q   <= '0;
      last_q  <= LAST_10;
      ocnt_q  <= '0;
      busy_q  <= 1'b0;
      txd_q   <= 1'b1;
    end else if (fmt_i == FMT_OFF) begin
      busy_q <= 1'b0;
      txd_q  <= 1'b1;
    end else if (!busy_q) begin
      if (wr_i) begin
        // stop, ninth (or second stop), data, start
        frame_q <= {1'b1, (fmt_i == FMT_11) ? tb8_i : 1'b1, wdata_i, 1'b0};
        last_q  <= (fmt_i == FMT_11) ? LAST_11 : LAST_10;
        idx_q   <= '0;
        ocnt_q  <= '0;
        busy_q  <= 1'b1;
        txd_q   <= 1'b0;
      end
    end else if (tick_i) begin
      if (ocnt_q == OCNT_LAST) begin
        ocnt_q <= '0;
        if (idx_q == last_q) begin
          busy_q <= 1'b0;
          txd_q  <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
          txd_q <= frame_q[idx_q + 1'b1];
        end
      end else begin
        ocnt_q <= ocnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ti_q <= 1'b0;
    else if (ti_set)   ti_q <= 1'b1;
    else if (ti_clr_i) ti_q <= 1'b0;
  end

  assign txd_o = txd_q;
  assign ti_o  = ti_q;

  AST_TX_IDLE_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> txd_q); // R2
  AST_TI_AT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ti_q) |-> (txd_q && busy_q)); // R4
  AST_TI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ti_q && !ti_clr_i) |=> ti_q); // R4
  AST_WR_BUSY_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && wr_i && !tick_i && fmt_i != FMT_OFF) |=> $stable(frame_q)); // R4
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
  import mp_uart_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  fmt_e          fmt_i,
  input  logic          ren_i,
  input  logic          sm2_i,
  input  logic          ovr_en_i,
  input  logic          ri_clr_i,
  input  logic          rxd_i,
  output logic [DW-1:0] rbuf_o,
  output logic          rb8_o,
  output logic          ri_o
);
  localparam int IW = $clog2(DW + 3);
  localparam int OW = $clog2(OVS);
  localparam int MID = OVS / 2;
  localparam logic [OW-1:0] OCNT_LAST = OW'(OVS - 1);
  localparam logic [OW-1:0] S_A = OW'(MID - 1);
  localparam logic [OW-1:0] S_B = OW'(MID);
  localparam logic [OW-1:0] S_C = OW'(MID + 1);
  localparam logic [IW-1:0] LAST_10 = IW'(DW + 1);
  localparam logic [IW-1:0] LAST_11 = IW'(DW + 2);
  localparam logic [IW-1:0] NINTH   = IW'(DW + 1);

  logic          s1_q, s2_q, prev_q;
  logic          active_q, long_q, ninth_q;
  logic [IW-1:0] idx_q;
  logic [OW-1:0] ocnt_q;
  logic [1:0]    votes_q;
  logic [DW-1:0] shreg_q, rbuf_q;
  logic          rb8_q, ri_q;
  logic          bitv, decide, last_bit, tag, accept;

  assign bitv     = (votes_q + {1'b0, s2_q}) >= 2'd2;
  assign decide   = active_q && tick_i && (ocnt_q == S_C);
  assign last_bit = idx_q == (long_q ? LAST_11 : LAST_10);
  assign tag      = long_q ? ninth_q : bitv;
  assign accept   = decide && last_bit && (ovr_en_i || !ri_q) && (!sm2_i || tag);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= rxd_i;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= 1'b1;
      active_q <= 1'b0;
      long_q   <= 1'b0;
      ninth_q  <= 1'b0;
      idx_q    <= '0;
      ocnt_q   <= '0;
      votes_q  <= '0;
      shreg_q  <= '0;
    end else if (!ren_i || fmt_i == FMT_OFF) begin
      active_q <= 1'b0;
      prev_q   <= 1'b1;
    end else if (tick_i) begin
      if (!active_q) begin
        prev_q <= s2_q;
        if (prev_q && !s2_q) begin
          active_q <= 1'b1;
          long_q   <= fmt_i == FMT_11;
          idx_q    <= '0;
          ocnt_q   <= '0;
          votes_q  <= '0;
        end
      end else begin
        if (ocnt_q == S_A || ocnt_q == S_B) votes_q <= votes_q + {1'b0, s2_q};
        if (ocnt_q == S_C) begin
          if (idx_q == '0) begin
            if (bitv) begin
              active_q <= 1'b0;  // false start
              prev_q   <= s2_q;
            end
          end else if (last_bit) begin
            active_q <= 1'b0;
            prev_q   <= s2_q;
          end else if (idx_q == NINTH) begin
            ninth_q <= bitv;
          end else begin
            shreg_q <= {bitv, shreg_q[DW-1:1]};
          end
        end
        if (ocnt_q == OCNT_LAST) begin
          ocnt_q  <= '0;
          votes_q <= '0;
          idx_q   <= idx_q + 1'b1;
        end else begin
          ocnt_q <= ocnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbuf_q <= '0;
      rb8_q  <= 1'b0;
    end else if (accept) begin
      rbuf_q <= shreg_q;
      rb8_q  <= tag;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ri_q <= 1'b0;
    else if (accept)   ri_q <= 1'b1;
    else if (ri_clr_i) ri_q <= 1'b0;
  end

  assign rbuf_o = rbuf_q;
  assign rb8_o  = rb8_q;
  assign ri_o   = ri_q;

  AST_NO_OVERWRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ri_q && !ovr_en_i) |=> ($stable(rbuf_q) && $stable(rb8_q))); // R6
  AST_REN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ren_i |=> !active_q); // R9
  AST_RI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ri_q && !ri_clr_i) |=> ri_q); // R10
  AST_RI_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ri_q && !active_q) |=> !ri_q); // R5
endmodule

// File: rtl/mp_uart.sv
module mp_uart
  import mp_uart_pkg::*;
#(
  parameter int OVS      = 16,
  parameter int SLOW_DIV = 64,
  parameter int FAST_DIV = 32,
  parameter int DW       = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          baud_tick_i,
  input  logic          sm0_i,
  input  logic          sm1_i,
  input  logic          sm2_i,
  input  logic          smod_i,
  input  logic          ren_i,
  input  logic          ovr_en_i,
  input  logic          tb8_i,
  input  logic          buf_wr_i,
  input  logic [DW-1:0] buf_wdata_i,
  input  logic          ti_clr_i,
  input  logic          ri_clr_i,
  input  logic          rxd_i,
  output logic          txd_o,
  output logic          ti_o,
  output logic          ri_o,
  output logic          rb8_o,
  output logic [DW-1:0] rbuf_o
);
  fmt_e fmt;
  logic tick;

  assign fmt = decode_fmt(sm0_i, sm1_i);

  mp_uart_rate #(.OVS(OVS), .SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_rate (
    .clk_i, .rst_ni, .fmt_i(fmt), .smod_i, .baud_tick_i, .tick_o(tick)
  );

  mp_uart_tx #(.OVS(OVS), .DW(DW)) u_tx (
    .clk_i, .rst_ni, .tick_i(tick), .fmt_i(fmt), .wr_i(buf_wr_i),
    .wdata_i(buf_wdata_i), .tb8_i, .ti_clr_i, .txd_o, .ti_o
  );

  mp_uart_rx #(.OVS(OVS), .DW(DW)) u_rx (
    .clk_i, .rst_ni, .tick_i(tick), .fmt_i(fmt), .ren_i, .sm2_i, .ovr_en_i,
    .ri_clr_i, .rxd_i, .rbuf_o, .rb8_o, .ri_o
  );

  AST_OFF_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt == FMT_OFF) |=> txd_o); // R1
  AST_OFF_NO_RI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt == FMT_OFF && !ri_o) |=> !ri_o); // R1
endmodule

// File: tb/mp_uart_tb_top.sv
`timescale 1ns/1ps
module mp_uart_tb_top;
  localparam int BAUD_P = 3;

  logic clk = 1'b0, rst_ni = 1'b0, baud_tick = 1'b0;
  logic sm0 = 1'b0, sm1 = 1'b1, sm2 = 1'b0, smod = 1'b0, ren = 1'b1;
  logic ovr_en = 1'b0, tb8 = 1'b0, buf_wr = 1'b0, ti_clr = 1'b0, ri_clr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic rxd_drv = 1'b1, lb = 1'b0;
  logic txd, ti, ri, rb8;
  logic [7:0] rbuf;

  int total = 0, bad = 0;
  int bit_clk = 16 * BAUD_P;
  int nbits = 10;
  bit finished = 1'b0;

  logic [8:0] tx_q[$];
  logic [8:0] rx_q[$];

  always #2 clk = ~clk;

  mp_uart dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .baud_tick_i(baud_tick), .sm0_i(sm0),
    .sm1_i(sm1), .sm2_i(sm2), .smod_i(smod), .ren_i(ren), .ovr_en_i(ovr_en),
    .tb8_i(tb8), .buf_wr_i(buf_wr), .buf_wdata_i(wdata), .ti_clr_i(ti_clr),
    .ri_clr_i(ri_clr), .rxd_i(lb ? txd : rxd_drv), .txd_o(txd), .ti_o(ti),
    .ri_o(ri), .rb8_o(rb8), .rbuf_o(rbuf)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      baud_tick = (c == 0);
      c = (c == BAUD_P - 1) ? 0 : c + 1;
    end
  end

  task automatic set_fmt(input logic s0, input logic s1, input logic sd);
    @(negedge clk);
    sm0 = s0; sm1 = s1; smod = sd;
    if ({s0, s1} == 2'b10) begin
      nbits = 11; bit_clk = sd ? 32 : 64;
    end else begin
      nbits = 10; bit_clk = 16 * BAUD_P;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic tx_write(input logic [7:0] d, input logic n, input bit expect_frame);
    @(negedge clk);
    wdata = d; tb8 = n; buf_wr = 1'b1;
    if (expect_frame) tx_q.push_back({n, d});
    @(negedge clk);
    buf_wr = 1'b0;
  endtask

  task automatic wait_frame();
    repeat (bit_clk * (nbits + 1)) @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] d, input logic n, input logic stp,
                         input bit expect_acc, input logic exp_rb8);
    if (expect_acc) rx_q.push_back({exp_rb8, d});
    @(negedge clk);
    rxd_drv = 1'b0;
    repeat (bit_clk) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd_drv = d[i];
      repeat (bit_clk) @(negedge clk);
    end
    if (nbits == 11) begin
      rxd_drv = n;
      repeat (bit_clk) @(negedge clk);
    end
    rxd_drv = stp;
    repeat (bit_clk) @(negedge clk);
    rxd_drv = 1'b1;
    repeat (bit_clk) @(negedge clk);
  endtask

  task automatic clr_ri();
    @(negedge clk); ri_clr = 1'b1;
    @(negedge clk); ri_clr = 1'b0;
    chk(ri == 1'b0, "R10 ri cleared", ri, 0);
  endtask

  task automatic clr_ti();
    @(negedge clk); ti_clr = 1'b1;
    @(negedge clk); ti_clr = 1'b0;
    chk(ti == 1'b0, "R4 ti cleared", ti, 0);
  endtask

  // transmit monitor
  initial begin
    logic [10:0] got;
    logic [8:0]  e;
    forever begin
      @(negedge txd);
      got = '1;
      repeat (bit_clk / 2) @(negedge clk);
      got[0] = txd;
      for (int i = 1; i < nbits; i++) begin
        repeat (bit_clk) @(negedge clk);
        got[i] = txd;
      end
      chk(ti == 1'b1, "R4 ti at stop", ti, 1);
      if (tx_q.size() == 0) begin
        chk(1'b0, "R4 unexpected tx frame", int'(got), 0);
      end else begin
        e = tx_q.pop_front();
        chk(got[0] == 1'b0, "R2 start bit", got[0], 0);
        chk(got[8:1] == e[7:0], "R2 tx data", got[8:1], e[7:0]);
        if (nbits == 11) chk(got[9] == e[8], "R3 ninth bit", got[9], e[8]);
        chk(got[nbits-1] == 1'b1, "R2 stop bit", got[nbits-1], 1);
      end
    end
  end

  // receive monitor
  initial begin
    logic ri_prev = 1'b0;
    logic [8:0] e;
    forever begin
      @(negedge clk);
      if (rst_ni && ri && !ri_prev) begin
        if (rx_q.size() == 0) begin
          chk(1'b0, "R7 unexpected RI", {rb8, rbuf}, 0);
        end else begin
          e = rx_q.pop_front();
          chk({rb8, rbuf} == e, "R7 R8 rx item", {rb8, rbuf}, e);
        end
      end
      ri_prev = ri;
    end
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1, "R2 reset txd idle", txd, 1);
    chk(ti == 1'b0, "R4 reset ti", ti, 0);
    chk(ri == 1'b0, "R10 reset ri", ri, 0);
    chk(rbuf == 8'h00, "R7 reset rbuf", rbuf, 0);

    // short format transmit
    set_fmt(1'b0, 1'b1, 1'b0);
    tx_write(8'hA5, 1'b0, 1'b1);
    wait_frame();
    chk(ti == 1'b1, "R4 ti held", ti, 1);
    clr_ti();
    // write while busy is dropped
    tx_write(8'h5A, 1'b0, 1'b1);
    repeat (bit_clk * 4) @(negedge clk);
    tx_write(8'hFF, 1'b0, 1'b0);
    wait_frame();
    chk(tx_q.size() == 0, "R4 busy write ignored", tx_q.size(), 0);
    clr_ti();

    // short format receive
    send_rx(8'h3C, 1'b0, 1'b1, 1'b1, 1'b1);
    chk(ri == 1'b1 && rbuf == 8'h3C, "R7 accepted", rbuf, 8'h3C);
    clr_ri();
    send_rx(8'hC3, 1'b0, 1'b0, 1'b1, 1'b0);
    chk(rb8 == 1'b0, "R7 bad stop accepted sm2=0", rb8, 0);
    clr_ri();
    sm2 = 1'b1;
    send_rx(8'h77, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(ri == 1'b0, "R7 bad stop dropped sm2=1", ri, 0);
    chk(rbuf == 8'hC3, "R7 rbuf kept", rbuf, 8'hC3);
    sm2 = 1'b0;

    // overrun guard
    send_rx(8'h11, 1'b0, 1'b1, 1'b1, 1'b1);
    send_rx(8'h22, 1'b0, 1'b1, 1'b0, 1'b1);
    chk(rbuf == 8'h11, "R6 unread buffer kept", rbuf, 8'h11);
    chk(ri == 1'b1, "R6 ri still set", ri, 1);
    ovr_en = 1'b1;
    send_rx(8'h33, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(rbuf == 8'h33, "R6 overwrite", rbuf, 8'h33);
    chk(rb8 == 1'b0, "R6 overwrite rb8", rb8, 0);
    ovr_en = 1'b0;
    clr_ri();

    // false start
    @(negedge clk);
    rxd_drv = 1'b0;
    repeat (bit_clk / 4) @(negedge clk);
    rxd_drv = 1'b1;
    wait_frame();
    chk(ri == 1'b0, "R5 glitch rejected", ri, 0);
    send_rx(8'h96, 1'b0, 1'b1, 1'b1, 1'b1);
    chk(rbuf == 8'h96, "R5 frame after glitch", rbuf, 8'h96);
    clr_ri();

    // receiver disabled
    ren = 1'b0;
    send_rx(8'h44, 1'b0, 1'b1, 1'b0, 1'b0);
    chk(ri == 1'b0, "R9 ren off", ri, 0);
    chk(rbuf == 8'h96, "R9 rbuf kept", rbuf, 8'h96);
    ren = 1'b1;

    // long format, slow rate
    set_fmt(1'b1, 1'b0, 1'b0);
    tx_write(8'h81, 1'b1, 1'b1);
    wait_frame();
    clr_ti();
    tx_write(8'h7E, 1'b0, 1'b1);
    wait_frame();
    clr_ti();
    sm2 = 1'b1;
    send_rx(8'h55, 1'b0, 1'b1, 1'b0, 1'b0);
    chk(ri == 1'b0, "R8 data frame filtered", ri, 0);
    send_rx(8'h42, 1'b1, 1'b0, 1'b1, 1'b1);
    chk(rb8 == 1'b1 && rbuf == 8'h42, "R8 address frame", rbuf, 8'h42);
    clr_ri();
    sm2 = 1'b0;
    send_rx(8'hE7, 1'b0, 1'b1, 1'b1, 1'b0);
    chk(rb8 == 1'b0 && rbuf == 8'hE7, "R8 sm2=0 accepts", rbuf, 8'hE7);
    clr_ri();

    // long format, doubled rate
    set_fmt(1'b1, 1'b0, 1'b1);
    tx_write(8'hC9, 1'b1, 1'b1);
    wait_frame();
    clr_ti();
    send_rx(8'h18, 1'b1, 1'b1, 1'b1, 1'b1);
    clr_ri();

    // off formats
    set_fmt(1'b0, 1'b0, 1'b0);
    tx_write(8'h00, 1'b0, 1'b0);
    nbits = 10; bit_clk = 16 * BAUD_P;
    send_rx(8'h66, 1'b0, 1'b1, 1'b0, 1'b0);
    chk(txd == 1'b1 && ti == 1'b0, "R1 off no transmit", {ti, txd}, 1);
    chk(ri == 1'b0, "R1 off no receive", ri, 0);
    set_fmt(1'b1, 1'b1, 1'b0);
    nbits = 10; bit_clk = 16 * BAUD_P;
    tx_write(8'h0F, 1'b0, 1'b0);
    wait_frame();
    chk(txd == 1'b1 && ti == 1'b0, "R1 mode 11 off", {ti, txd}, 1);

    // duplex loopback
    set_fmt(1'b0, 1'b1, 1'b0);
    lb = 1'b1;
    rx_q.push_back({1'b1, 8'h69});
    tx_write(8'h69, 1'b0, 1'b1);
    wait_frame();
    chk(ri == 1'b1 && rbuf == 8'h69, "R11 loopback rx", rbuf, 8'h69);
    chk(ti == 1'b1, "R11 loopback tx", ti, 1);
    lb = 1'b0;
    clr_ri();
    clr_ti();

    held = rbuf;
    chk(held == 8'h69, "R10 rbuf after clear", held, 8'h69);
    chk(tx_q.size() == 0, "R2 tx queue drained", tx_q.size(), 0);
    chk(rx_q.size() == 0, "R7 rx queue drained", rx_q.size(), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule